// File: doc/BRIEF.md
# Time-Slot Interchange Core

This core moves 8-bit channel samples between four incoming and four outgoing time-division streams of 32 slots each. Serialisation, frame alignment and bus decoding sit outside it. Its interface is parallel. An input strobe delivers the byte of one slot index for all four incoming streams together, and each byte is kept in a 128-entry sample store addressed by stream and slot. An output strobe names the next outgoing slot index. One cycle later the core presents the byte and the drive enable for that slot on all four outgoing streams, ready for the serialiser to load at the slot boundary.

Each outgoing slot has two control entries. The first is a byte that either points at a stored sample or is itself a message byte. The second holds a message-select flag and a drive flag. A global message input treats every slot as a driven message slot. A drive-enable input, when low, puts every slot out of drive. A controller can read any stored sample through a one-word read port. Output fetches take priority over that port, and a controller read waits while an output fetch is under way.

Top module: `tsi_core`

## Requirements
- R1: After reset, out_valid, out_oe and cpu_ack are 0, and every sample-store and control entry reads as zero.
- R2: An in_wr cycle with index c stores byte [8s+7:8s] of in_bytes at sample address {s[1:0], c[4:0]} for each incoming stream s. A later controller read of that address returns the byte.
- R3: In a switched slot, bits 6:5 of the pointer entry select the source stream and bits 4:0 select the source slot. The output byte is the stored sample at that address, and bit 7 of the entry has no effect on the choice.
- R4: When bit 2 of a slot's flag entry is 1, the slot carries its pointer entry as a message byte, all 8 bits. Every later fetch of that slot gives the same byte until the entry is rewritten, whatever new samples arrive.
- R5: Bit 0 of the flag entry sets drive: 1 drives the slot and 0 leaves it undriven. An undriven slot reports oe 0 and a data byte of 0.
- R6: With glob_msg high and ode high, every slot is driven and carries its pointer entry as a message, whatever its flag entry holds.
- R7: With ode low, every slot is undriven with data 0. This holds whatever glob_msg and the flag entries hold.
- R8: A fetch (out_req with index out_chan) raises out_valid one cycle later together with out_data and out_oe. In a cycle that follows no fetch, out_valid and out_oe are 0.
- R9: A controller read (cpu_rd, cpu_addr) is answered with a one-cycle cpu_ack and cpu_data one cycle later when out_req is low. While out_req is high the read is held, and it is answered one cycle after the first cycle with out_req low.
- R10: Flag-entry bits other than 2 and 0 have no effect on the output.
- R11: Control writes (cm_we) go to the pointer entry when cm_part is 0 and to the flag entry when cm_part is 1, at outgoing stream cm_stream and slot cm_chan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_wr | input | 1 | Store incoming bytes for one slot index |
| in_chan | input | 5 | Incoming slot index |
| in_bytes | input | 32 | One byte per incoming stream, stream s at [8s+7:8s] |
| cm_we | input | 1 | Control entry write strobe |
| cm_part | input | 1 | 0 = pointer entry, 1 = flag entry |
| cm_stream | input | 2 | Outgoing stream of the entry |
| cm_chan | input | 5 | Outgoing slot of the entry |
| cm_wdata | input | 8 | Entry value |
| glob_msg | input | 1 | Force all slots to driven message mode |
| ode | input | 1 | Drive enable for all outgoing streams |
| out_req | input | 1 | Fetch the outgoing slot out_chan |
| out_chan | input | 5 | Outgoing slot index to fetch |
| out_valid | output | 1 | Fetched slot data present |
| out_data | output | 32 | One byte per outgoing stream |
| out_oe | output | 4 | Drive enable per outgoing stream |
| cpu_rd | input | 1 | Controller sample read request |
| cpu_addr | input | 7 | Sample address {stream, slot} |
| cpu_ack | output | 1 | Read answered |
| cpu_data | output | 8 | Read sample byte |

## Verification
The checker assumes that a controller read is not issued again while an earlier one is still held. The stimulus always waits for cpu_ack before it starts another read. The priority property assumes out_req is a strobe the core may act on every cycle, so fetches are sent with gaps and a read is once held across two back-to-back fetches. The per-slot drive and zero-byte rules are checked on every valid cycle and do not depend on which slot pattern the stimulus chose.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef enum logic {CM_LOW = 1'b0, CM_HIGH = 1'b1} cm_part_e;
  localparam int HI_MSG_BIT = 2;
  localparam int HI_EN_BIT  = 0;
endpackage

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
  parameter int NS = 4,
  parameter int NC = 32,
  parameter int W  = 8,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(NC),
  localparam int AW = SW + CW,
  localparam int DEPTH = NS * NC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [CW-1:0]   wr_chan,
  input  logic [NS*W-1:0] wr_bytes,
  input  logic [NS*AW-1:0] rd_addr,
  output logic [NS*W-1:0] rd_data,
  input  logic [AW-1:0]   cpu_addr,
  output logic [W-1:0]    cpu_q
);
  logic [W-1:0] mem [DEPTH];

  function automatic logic [AW-1:0] sample_addr(input logic [SW-1:0] s, input logic [CW-1:0] c);
    return {s, c};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr) begin
      for (int s = 0; s < NS; s++)
        mem[sample_addr(SW'(s), wr_chan)] <= wr_bytes[s*W +: W];
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_rd
    assign rd_data[g*W +: W] = mem[rd_addr[g*AW +: AW]];
  end

  assign cpu_q = mem[cpu_addr];
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int NS = 4,
  parameter int NC = 32,
  parameter int W  = 8,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(NC),
  localparam int AW = SW + CW,
  localparam int DEPTH = NS * NC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  cm_part_e        part,
  input  logic [SW-1:0]   wr_stream,
  input  logic [CW-1:0]   wr_chan,
  input  logic [W-1:0]    wdata,
  input  logic [CW-1:0]   rd_chan,
  output logic [NS*W-1:0] lo_q,
  output logic [NS-1:0]   msg_q,
  output logic [NS-1:0]   en_q
);
  logic [W-1:0] lo_mem [DEPTH];
  logic [DEPTH-1:0] msg_mem;
  logic [DEPTH-1:0] en_mem;
  logic [AW-1:0] wa;

  function automatic logic [AW-1:0] slot_addr(input logic [SW-1:0] s, input logic [CW-1:0] c);
    return {s, c};
  endfunction

  assign wa = slot_addr(wr_stream, wr_chan);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) lo_mem[i] <= '0;
      msg_mem <= '0;
      en_mem  <= '0;
    end else if (we) begin
      if (part == CM_HIGH) begin
        msg_mem[wa] <= wdata[HI_MSG_BIT];
        en_mem[wa]  <= wdata[HI_EN_BIT];
      end else begin
        lo_mem[wa] <= wdata;
      end
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_rd
    assign lo_q[g*W +: W] = lo_mem[slot_addr(SW'(g), rd_chan)];
    assign msg_q[g]       = msg_mem[slot_addr(SW'(g), rd_chan)];
    assign en_q[g]        = en_mem[slot_addr(SW'(g), rd_chan)];
  end
endmodule

// File: rtl/tsi_slot_sel.sv
module tsi_slot_sel #(
  parameter int W = 8
) (
  input  logic         glob_msg,
  input  logic         ode,
  input  logic [W-1:0] entry,
  input  logic         msg_flag,
  input  logic         en_flag,
  input  logic [W-1:0] sample,
  output logic         drive,
  output logic [W-1:0] byte_o
);
  function automatic logic as_message(input logic gm, input logic m);
    return gm | m;
  endfunction

  function automatic logic drives(input logic od, input logic gm, input logic e);
    return od & (gm | e);
  endfunction

  assign drive  = drives(ode, glob_msg, en_flag);
  assign byte_o = !drive ? '0 : (as_message(glob_msg, msg_flag) ? entry : sample);
endmodule

// File: rtl/tsi_core.sv
module tsi_core
  import tsi_pkg::*;
#(
  parameter int NS = 4,
  parameter int NC = 32,
  parameter int W  = 8,
  localparam int SW = $clog2(NS),
  localparam int CW = $clog2(NC),
  localparam int AW = SW + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_wr,
  input  logic [CW-1:0]   in_chan,
  input  logic [NS*W-1:0] in_bytes,
  input  logic            cm_we,
  input  logic            cm_part,
  input  logic [SW-1:0]   cm_stream,
  input  logic [CW-1:0]   cm_chan,
  input  logic [W-1:0]    cm_wdata,
  input  logic            glob_msg,
  input  logic            ode,
  input  logic            out_req,
  input  logic [CW-1:0]   out_chan,
  output logic            out_valid,
  output logic [NS*W-1:0] out_data,
  output logic [NS-1:0]   out_oe,
  input  logic            cpu_rd,
  input  logic [AW-1:0]   cpu_addr,
  output logic            cpu_ack,
  output logic [W-1:0]    cpu_data
);
  logic [NS*W-1:0]  lo_q;
  logic [NS-1:0]    msg_q;
  logic [NS-1:0]    en_q;
  logic [NS*AW-1:0] fetch_addr;
  logic [NS*W-1:0]  fetch_data;
  logic [NS*W-1:0]  slot_bytes;
  logic [NS-1:0]    slot_drive;
  logic [W-1:0]     cpu_q;

  // Controller read holding and arbitration
  logic            held_v;
  logic [AW-1:0]   held_a;
  logic            cpu_grant;
  logic [AW-1:0]   cpu_sel;

  assign cpu_grant = (cpu_rd | held_v) & ~out_req;
  assign cpu_sel   = held_v ? held_a : cpu_addr;

  tsi_data_mem #(.NS(NS), .NC(NC), .W(W)) u_dmem (
    .clk(clk), .rst_n(rst_n),
    .wr(in_wr), .wr_chan(in_chan), .wr_bytes(in_bytes),
    .rd_addr(fetch_addr), .rd_data(fetch_data),
    .cpu_addr(cpu_sel), .cpu_q(cpu_q)
  );

  tsi_conn_mem #(.NS(NS), .NC(NC), .W(W)) u_cmem (
    .clk(clk), .rst_n(rst_n),
    .we(cm_we), .part(cm_part_e'(cm_part)),
    .wr_stream(cm_stream), .wr_chan(cm_chan), .wdata(cm_wdata),
    .rd_chan(out_chan), .lo_q(lo_q), .msg_q(msg_q), .en_q(en_q)
  );

  for (genvar g = 0; g < NS; g++) begin : g_slot
    assign fetch_addr[g*AW +: AW] = lo_q[g*W +: AW];

    tsi_slot_sel #(.W(W)) u_sel (
      .glob_msg(glob_msg), .ode(ode),
      .entry(lo_q[g*W +: W]), .msg_flag(msg_q[g]), .en_flag(en_q[g]),
      .sample(fetch_data[g*W +: W]),
      .drive(slot_drive[g]), .byte_o(slot_bytes[g*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_oe    <= '0;
    end else begin
      out_valid <= out_req;
      out_data  <= out_req ? slot_bytes : '0;
      out_oe    <= out_req ? slot_drive : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v   <= 1'b0;
      held_a   <= '0;
      cpu_ack  <= 1'b0;
      cpu_data <= '0;
    end else begin
      cpu_ack <= cpu_grant;
      if (cpu_grant) begin
        cpu_data <= cpu_q;
        held_v   <= 1'b0;
      end else if (cpu_rd) begin
        held_v <= 1'b1;
        held_a <= cpu_addr;
      end
    end
  end
endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk #(
  parameter int NS = 4,
  parameter int W  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            out_req,
  input logic            ode,
  input logic            glob_msg,
  input logic            cpu_rd,
  input logic            cpu_grant,
  input logic            out_valid,
  input logic [NS*W-1:0] out_data,
  input logic [NS-1:0]   out_oe,
  input logic            cpu_ack
);
  logic dark_ok;
  always_comb begin
    dark_ok = 1'b1;
    for (int s = 0; s < NS; s++)
      if (!out_oe[s] && out_data[s*W +: W] != '0) dark_ok = 1'b0;
  end

  a_r8_fetch_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> out_valid);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_req |=> (!out_valid && out_oe == '0));
  a_r7_drive_off: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && !ode) |=> (out_oe == '0));
  a_r6_all_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && ode && glob_msg) |=> (&out_oe));
  a_r5_dark_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dark_ok);
  a_r9_output_first: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> !cpu_ack);
  a_r9_free_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !out_req) |=> cpu_ack);
  a_r9_grant_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_grant |=> cpu_ack);
endmodule

bind tsi_core tsi_core_chk #(.NS(NS), .W(W)) u_tsi_chk (
  .clk(clk), .rst_n(rst_n), .out_req(out_req), .ode(ode),
  .glob_msg(glob_msg), .cpu_rd(cpu_rd), .cpu_grant(cpu_grant),
  .out_valid(out_valid), .out_data(out_data), .out_oe(out_oe),
  .cpu_ack(cpu_ack)
);

// File: tb/test_tsi_core.sv
`timescale 1ns/1ps
module test_tsi_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_wr = 1'b0;
  logic [4:0]  in_chan = '0;
  logic [31:0] in_bytes = '0;
  logic        cm_we = 1'b0;
  logic        cm_part = 1'b0;
  logic [1:0]  cm_stream = '0;
  logic [4:0]  cm_chan = '0;
  logic [7:0]  cm_wdata = '0;
  logic        glob_msg = 1'b0;
  logic        ode = 1'b0;
  logic        out_req = 1'b0;
  logic [4:0]  out_chan = '0;
  logic        out_valid;
  logic [31:0] out_data;
  logic [3:0]  out_oe;
  logic        cpu_rd = 1'b0;
  logic [6:0]  cpu_addr = '0;
  logic        cpu_ack;
  logic [7:0]  cpu_data;

  int checks = 0;
  int fails = 0;
  logic [7:0] dm_m [128];

  always #10 clk = ~clk;

  tsi_core i_tsi_core (
    .clk(clk), .rst_n(rst_n), .in_wr(in_wr), .in_chan(in_chan), .in_bytes(in_bytes),
    .cm_we(cm_we), .cm_part(cm_part), .cm_stream(cm_stream), .cm_chan(cm_chan),
    .cm_wdata(cm_wdata), .glob_msg(glob_msg), .ode(ode), .out_req(out_req),
    .out_chan(out_chan), .out_valid(out_valid), .out_data(out_data), .out_oe(out_oe),
    .cpu_rd(cpu_rd), .cpu_addr(cpu_addr), .cpu_ack(cpu_ack), .cpu_data(cpu_data)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int s, int c, int f);
    return 8'(s * 37 + c * 11 + f * 101 + 5);
  endfunction
  function automatic bit is_msg(int c); return (c % 3) == 0; endfunction
  function automatic bit is_en(int c);  return (c % 4) != 1; endfunction
  function automatic logic [7:0] entry(int s, int c);
    if (is_msg(c)) return 8'(c * 9 + s * 64 + 200);
    return {(c == 7), 2'((s + c) % 4), 5'(31 - c)};
  endfunction
  function automatic logic [7:0] flags(int c);
    return 8'hA2 | (is_msg(c) ? 8'h04 : 8'h00) | (is_en(c) ? 8'h01 : 8'h00);
  endfunction
  function automatic logic exp_oe(int c, bit gm, bit od);
    return od & (gm | is_en(c));
  endfunction
  function automatic logic [7:0] exp_byte(int s, int c, bit gm, bit od);
    logic [7:0] e;
    e = entry(s, c);
    if (!exp_oe(c, gm, od)) return 8'h00;
    if (gm || is_msg(c)) return e;
    return dm_m[e[6:0]];
  endfunction

  task automatic wr_frame(int f);
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      in_wr = 1'b1; in_chan = 5'(c);
      in_bytes = {pat(3, c, f), pat(2, c, f), pat(1, c, f), pat(0, c, f)};
      for (int s = 0; s < 4; s++) dm_m[s * 32 + c] = pat(s, c, f);
    end
    @(negedge clk) in_wr = 1'b0;
  endtask

  task automatic cm_write(bit part, int s, int c, logic [7:0] d);
    @(negedge clk);
    cm_we = 1'b1; cm_part = part; cm_stream = 2'(s); cm_chan = 5'(c); cm_wdata = d;
    @(negedge clk) cm_we = 1'b0;
  endtask

  task automatic cpu_read(int a, string req);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 7'(a);
    @(negedge clk) cpu_rd = 1'b0;
    check(req, "read ack", 32'(cpu_ack), 32'd1);
    check(req, $sformatf("read data addr %0d", a), 32'(cpu_data), 32'(dm_m[a]));
  endtask

  task automatic fetch(int c);
    @(negedge clk);
    out_req = 1'b1; out_chan = 5'(c);
    @(negedge clk) out_req = 1'b0;
  endtask

  task automatic sweep(bit gm, bit od);
    string req;
    glob_msg = gm; ode = od;
    for (int c = 0; c < 32; c++) begin
      fetch(c);
      check("R8", "valid after fetch", 32'(out_valid), 32'd1);
      for (int s = 0; s < 4; s++) begin
        if (!od) req = "R7";
        else if (gm) req = "R6";
        else if (!is_en(c)) req = "R5 R10";
        else if (is_msg(c)) req = "R4 R10";
        else req = (c == 7) ? "R3 bit7" : "R3 R11";
        check(req, $sformatf("oe s%0d c%0d", s, c), 32'(out_oe[s]), 32'(exp_oe(c, gm, od)));
        check(req, $sformatf("data s%0d c%0d", s, c), 32'(out_data[s*8 +: 8]), 32'(exp_byte(s, c, gm, od)));
      end
    end
    @(negedge clk);
    check("R8", "valid drops when idle", 32'(out_valid), 32'd0);
    check("R8", "oe idle", 32'(out_oe), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) dm_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "valid after reset", 32'(out_valid), 32'd0);
    check("R1", "oe after reset", 32'(out_oe), 32'd0);
    check("R1", "ack after reset", 32'(cpu_ack), 32'd0);
    cpu_read(0, "R1");
    cpu_read(127, "R1");
    glob_msg = 1'b1; ode = 1'b1;
    fetch(5);
    check("R1", "entry zero after reset", 32'(out_data), 32'd0);

    // R2 sample storage
    wr_frame(0);
    for (int a = 0; a < 128; a++) cpu_read(a, "R2");

    // R11 program every control entry
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 32; c++) begin
        cm_write(1'b0, s, c, entry(s, c));
        cm_write(1'b1, s, c, flags(c));
      end

    sweep(1'b0, 1'b1);
    // R4 messages persist while new samples arrive, R3 follows them
    wr_frame(1);
    sweep(1'b0, 1'b1);
    sweep(1'b1, 1'b1);
    sweep(1'b1, 1'b0);
    sweep(1'b0, 1'b0);

    // R4 rewrite of a message entry takes effect
    cm_write(1'b0, 2, 3, 8'h5A);
    glob_msg = 1'b0; ode = 1'b1;
    fetch(3);
    check("R4", "rewritten message", 32'(out_data[23:16]), 32'h5A);

    // R9 controller read held behind fetches
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 7'd77; out_req = 1'b1; out_chan = 5'd4;
    @(negedge clk);
    cpu_rd = 1'b0; out_chan = 5'd8;
    check("R9", "held while fetching", 32'(cpu_ack), 32'd0);
    @(negedge clk);
    out_req = 1'b0;
    check("R9", "still held", 32'(cpu_ack), 32'd0);
    check("R8", "back-to-back fetch valid", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R9", "held read answered", 32'(cpu_ack), 32'd1);
    check("R9", "held read data", 32'(cpu_data), 32'(dm_m[77]));
    @(negedge clk);
    check("R9", "ack is one pulse", 32'(cpu_ack), 32'd0);
    cpu_read(33, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule